// File: doc/BRIEF.md
# Paired-page translation lookaside buffer

This block is a fully associative translation buffer holding a parameterised number of entries (16 by default). Every entry translates a pair of neighbouring virtual pages, an even one and an odd one, to two independent physical frames. The page size of an entry is set by its own page mask, and the smallest page is 4 KiB.

A lookup is purely combinational. The block takes a 32-bit virtual address, an access kind and the current 8-bit address-space identifier, and it returns a result code. On a successful translation it also returns the physical address and a flag that says whether the page may be written.

A separate write port replaces a whole entry, chosen by index, at the next clock edge. Segment decoding, exception raising and the choice of victim entry are left to the surrounding logic.

Top module: `pair_tlb`

## Requirements
- R1: An entry hits only when its hidden flag is clear, its address bits above the effective mask equal those of the lookup address, and either its global flag is set or its identifier equals `lk_asid`.
- R2: The effective mask is the entry page mask ORed with 0x1FFF. With a page mask of 0 each page is 4 KiB and the pair covers 8 KiB. Low page-mask bits below bit 13 have no effect.
- R3: The odd half is selected when the address bit at the highest set bit of the effective mask is 1. That bit is bit 12 for page mask 0 and bit 14 for page mask 0x6000. Otherwise the even half is used.
- R4: For a hit, the checks on the selected half run in this order, and the first one that fails sets the result. Valid clear gives INVALID (2). Execute-inhibit set on a fetch (`lk_acc`=0) gives EXEC_INHIBIT (3). Read-inhibit set on a load (`lk_acc`=1) gives READ_INHIBIT (4). Dirty clear on a store (`lk_acc`=2) gives MODIFY (5).
- R5: When all checks pass, the result is MATCH (0) and `lk_pa` is the selected frame ORed with the address bits under the effective mask shifted right by one. A store to a half whose dirty bit is clear never returns MATCH.
- R6: `lk_writable` is 1 only with MATCH, and then it equals the selected half's dirty bit. For any other result, `lk_writable` and `lk_pa` are 0.
- R7: When no entry hits, the result is NO_MATCH (1).
- R8: When several entries hit, the lowest-numbered one decides the result.
- R9: A write with `wr_en` set stores the entry at `wr_idx` at the next rising edge. A lookup in the same cycle still sees the old contents.
- R10: While `rst_n` is low at a rising edge, every entry is cleared and hidden, so after reset every lookup gives NO_MATCH.

The half flag fields `wr_flags0` and `wr_flags1` are packed as bit 3 execute-inhibit, bit 2 read-inhibit, bit 1 dirty, bit 0 valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_va | input | 32 | Lookup virtual address |
| lk_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| lk_asid | input | 8 | Current address-space identifier |
| lk_result | output | 3 | Result code (see R4 to R7) |
| lk_pa | output | 32 | Translated physical address, 0 unless MATCH |
| lk_writable | output | 1 | Page writable, valid with MATCH |
| wr_en | input | 1 | Write the entry at `wr_idx` |
| wr_idx | input | 4 | Entry index to write |
| wr_vpn | input | 32 | Virtual page pair address of the entry |
| wr_pmask | input | 32 | Page mask, ones from bit 13 upward |
| wr_asid | input | 8 | Entry identifier |
| wr_glob | input | 1 | Entry matches any identifier |
| wr_hide | input | 1 | Entry hidden from lookups |
| wr_pfn0 | input | 32 | Even-half physical frame |
| wr_pfn1 | input | 32 | Odd-half physical frame |
| wr_flags0 | input | 4 | Even-half flags |
| wr_flags1 | input | 4 | Odd-half flags |

## Verification
The assertions assume three things about the inputs. Each page mask is a contiguous run of ones starting at bit 13. Each frame has zeros in every bit that its half's offset covers. The access kind never takes the value 3. Under these assumptions a translated address keeps its low 12 bits, and a store that returns MATCH is always writable. The stimulus builds every page mask as a shifted run of ones, clears the offset bits of every frame before writing it, and draws access kinds only from 0 to 2.

// File: rtl/pair_tlb_pkg.sv
// Shared widths, entry layout and result codes for the paired-page TLB.
// Assumes a 32-bit virtual and physical space and 4 KiB minimum pages.
package pair_tlb_pkg;

    localparam int VA_W   = 32;
    localparam int PA_W   = 32;
    localparam int ASID_W = 8;
    localparam int OFS_W  = 13;   // bits always inside the effective mask

    typedef struct packed {
        logic xi;   // execute inhibit
        logic ri;   // read inhibit
        logic d;    // dirty / writable
        logic v;    // valid
    } half_flags_t;

    typedef struct packed {
        logic [VA_W-1:0]   vpn;
        logic [VA_W-1:0]   pmask;
        logic [ASID_W-1:0] asid;
        logic              glob;
        logic              hide;
        logic [PA_W-1:0]   pfn0;
        logic [PA_W-1:0]   pfn1;
        half_flags_t       f0;
        half_flags_t       f1;
    } tlb_entry_t;

    typedef enum logic [2:0] {
        RES_MATCH    = 3'd0,
        RES_NOMATCH  = 3'd1,
        RES_INVALID  = 3'd2,
        RES_XINHIBIT = 3'd3,
        RES_RINHIBIT = 3'd4,
        RES_MODIFY   = 3'd5
    } result_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2
    } access_e;

    localparam tlb_entry_t ENTRY_CLEARED = '{hide: 1'b1, default: '0};

endpackage

// File: rtl/pair_tlb_store.sv
// Entry storage: one register per entry, written whole by index.
// Assumes wr_idx is below ENTRIES; writes land at the next rising edge.
module pair_tlb_store
    import pair_tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  tlb_entry_t                   wr_entry,
    output tlb_entry_t [ENTRIES-1:0]     ents
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        // Hold one entry; clear and hide it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ents[g] <= ENTRY_CLEARED;
            else if (wr_en && wr_idx == IDX_W'(g))
                ents[g] <= wr_entry;
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ents[$past(wr_idx)] == $past(wr_entry)); // R9

endmodule

// File: rtl/pair_tlb_match.sv
// Per-entry tag compare and half selection, one copy per entry.
// Assumes page masks are contiguous ones from bit OFS_W upward.
module pair_tlb_match
    import pair_tlb_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  tlb_entry_t [ENTRIES-1:0]            ents,
    input  logic [VA_W-1:0]                     va,
    input  logic [ASID_W-1:0]                   asid,
    output logic [ENTRIES-1:0]                  hit,
    output half_flags_t [ENTRIES-1:0]           hflags,
    output logic [ENTRIES-1:0][PA_W-1:0]        hpfn,
    output logic [ENTRIES-1:0][VA_W-1:0]        hoff
);

    localparam logic [VA_W-1:0] LOW_MASK = VA_W'((1 << OFS_W) - 1);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [VA_W-1:0] emask;
        logic            tag_ok;
        logic            id_ok;
        logic            odd;

        // Compare tag and identifier, then pick the even or odd half.
        always_comb begin
            emask     = ents[g].pmask | LOW_MASK;
            tag_ok    = ((va ^ ents[g].vpn) & ~emask) == '0;
            id_ok     = ents[g].glob || (ents[g].asid == asid);
            hit[g]    = tag_ok && id_ok && !ents[g].hide;
            odd       = |(va & emask & ~(emask >> 1));
            hflags[g] = odd ? ents[g].f1 : ents[g].f0;
            hpfn[g]   = odd ? ents[g].pfn1 : ents[g].pfn0;
            hoff[g]   = emask >> 1;
        end
    end

endmodule

// File: rtl/pair_tlb_resolve.sv
// Picks the lowest hitting entry and runs the ordered permission checks.
// Assumes access kind 3 is never presented.
module pair_tlb_resolve
    import pair_tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ENTRIES-1:0]           hit,
    input  half_flags_t [ENTRIES-1:0]    hflags,
    input  logic [ENTRIES-1:0][PA_W-1:0] hpfn,
    input  logic [ENTRIES-1:0][VA_W-1:0] hoff,
    input  logic [VA_W-1:0]              va,
    input  access_e                      acc,
    output result_e                      result,
    output logic [PA_W-1:0]              pa,
    output logic                         writable
);

    logic [IDX_W-1:0]   sel;
    logic               found;
    logic [ENTRIES-1:0] win;
    half_flags_t        hf;

    // Priority pick: scan downwards so the lowest hit index remains.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel   = IDX_W'(i);
                found = 1'b1;
            end
        end
        win      = '0;
        win[sel] = found;
    end

    // Ordered checks on the chosen half, then address and writable flag.
    always_comb begin
        hf = hflags[sel];
        if (!found)
            result = RES_NOMATCH;
        else if (!hf.v)
            result = RES_INVALID;
        else if (acc == ACC_FETCH && hf.xi)
            result = RES_XINHIBIT;
        else if (acc == ACC_LOAD && hf.ri)
            result = RES_RINHIBIT;
        else if (acc == ACC_STORE && !hf.d)
            result = RES_MODIFY;
        else
            result = RES_MATCH;
        if (result == RES_MATCH) begin
            pa       = hpfn[sel] | PA_W'(va & hoff[sel]);
            writable = hf.d;
        end else begin
            pa       = '0;
            writable = 1'b0;
        end
    end

    AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win) && ((win & hit) == win)); // R8
    AST_NOHIT_NOMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |-> (result == RES_NOMATCH)); // R7

endmodule

// File: rtl/pair_tlb.sv
// Paired-page TLB top: storage, per-entry compare and result resolution.
// Assumes contiguous page masks, offset-aligned frames and lk_acc below 3.
module pair_tlb
    import pair_tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       lk_va,
    input  logic [1:0]        lk_acc,
    input  logic [7:0]        lk_asid,
    output logic [2:0]        lk_result,
    output logic [31:0]       lk_pa,
    output logic              lk_writable,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_vpn,
    input  logic [31:0]       wr_pmask,
    input  logic [7:0]        wr_asid,
    input  logic              wr_glob,
    input  logic              wr_hide,
    input  logic [31:0]       wr_pfn0,
    input  logic [31:0]       wr_pfn1,
    input  logic [3:0]        wr_flags0,
    input  logic [3:0]        wr_flags1
);

    tlb_entry_t                   wr_entry;
    tlb_entry_t [ENTRIES-1:0]     ents;
    logic [ENTRIES-1:0]           hit;
    half_flags_t [ENTRIES-1:0]    hflags;
    logic [ENTRIES-1:0][PA_W-1:0] hpfn;
    logic [ENTRIES-1:0][VA_W-1:0] hoff;
    result_e                      result;

    // Assemble the incoming entry from the write port fields.
    always_comb begin
        wr_entry.vpn   = wr_vpn;
        wr_entry.pmask = wr_pmask;
        wr_entry.asid  = wr_asid;
        wr_entry.glob  = wr_glob;
        wr_entry.hide  = wr_hide;
        wr_entry.pfn0  = wr_pfn0;
        wr_entry.pfn1  = wr_pfn1;
        wr_entry.f0    = half_flags_t'(wr_flags0);
        wr_entry.f1    = half_flags_t'(wr_flags1);
    end

    pair_tlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .ents     (ents)
    );

    pair_tlb_match #(.ENTRIES(ENTRIES)) u_match (
        .ents   (ents),
        .va     (lk_va),
        .asid   (lk_asid),
        .hit    (hit),
        .hflags (hflags),
        .hpfn   (hpfn),
        .hoff   (hoff)
    );

    pair_tlb_resolve #(.ENTRIES(ENTRIES)) u_resolve (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .hflags   (hflags),
        .hpfn     (hpfn),
        .hoff     (hoff),
        .va       (lk_va),
        .acc      (access_e'(lk_acc)),
        .result   (result),
        .pa       (lk_pa),
        .writable (lk_writable)
    );

    assign lk_result = result;

    AST_WRITABLE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        lk_writable |-> (lk_result == RES_MATCH)); // R6
    AST_STORE_MATCH_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_result == RES_MATCH && lk_acc == ACC_STORE) |-> lk_writable); // R5
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_result == RES_MATCH) |-> (lk_pa[OFS_W-2:0] == lk_va[OFS_W-2:0])); // R2
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_result != RES_MATCH) |-> (lk_pa == '0)); // R6

endmodule

// File: tb/pair_tlb_bench.sv
module pair_tlb_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_va = '0;
    logic [1:0]  lk_acc = '0;
    logic [7:0]  lk_asid = '0;
    logic [2:0]  lk_result;
    logic [31:0] lk_pa;
    logic        lk_writable;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_vpn = '0, wr_pmask = '0, wr_pfn0 = '0, wr_pfn1 = '0;
    logic [7:0]  wr_asid = '0;
    logic        wr_glob = 1'b0, wr_hide = 1'b0;
    logic [3:0]  wr_flags0 = '0, wr_flags1 = '0;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    chk_on  = 1'b0;
    bit    done    = 1'b0;
    string cur_tag = "R10";

    // behavioural reference state
    logic [31:0] m_vpn [16];
    logic [31:0] m_mask[16];
    logic [31:0] m_pfn0[16];
    logic [31:0] m_pfn1[16];
    logic [7:0]  m_asid[16];
    bit          m_glob[16];
    bit          m_hide[16];
    logic [3:0]  m_f0  [16];
    logic [3:0]  m_f1  [16];

    always #4 clk = ~clk;

    pair_tlb u_pair_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_va(lk_va), .lk_acc(lk_acc), .lk_asid(lk_asid),
        .lk_result(lk_result), .lk_pa(lk_pa), .lk_writable(lk_writable),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_pmask(wr_pmask),
        .wr_asid(wr_asid), .wr_glob(wr_glob), .wr_hide(wr_hide),
        .wr_pfn0(wr_pfn0), .wr_pfn1(wr_pfn1),
        .wr_flags0(wr_flags0), .wr_flags1(wr_flags1)
    );

    task automatic model(input logic [31:0] va, input logic [1:0] acc,
                         input logic [7:0] asid, output logic [2:0] r,
                         output logic [31:0] pa, output logic w);
        bit found = 0;
        r = 3'd1; pa = '0; w = 1'b0;
        for (int i = 0; i < 16; i++) begin
            logic [31:0] m;
            logic [3:0]  f;
            bit          odd;
            m = m_mask[i] | 32'h1FFF;
            if (!found && !m_hide[i] && (m_glob[i] || m_asid[i] == asid)
                && ((va & ~m) == (m_vpn[i] & ~m))) begin
                found = 1;
                odd = (va & m & ~(m >> 1)) != 0;
                f = odd ? m_f1[i] : m_f0[i];
                if (!f[0]) r = 3'd2;
                else if (acc == 2'd0 && f[3]) r = 3'd3;
                else if (acc == 2'd1 && f[2]) r = 3'd4;
                else if (acc == 2'd2 && !f[1]) r = 3'd5;
                else begin
                    r  = 3'd0;
                    pa = (odd ? m_pfn1[i] : m_pfn0[i]) | (va & (m >> 1));
                    w  = f[1];
                end
            end
        end
    endtask

    // Compare outputs with the model in the middle of every cycle.
    always @(negedge clk) begin
        if (chk_on) begin
            logic [2:0]  er;
            logic [31:0] ep;
            logic        ew;
            model(lk_va, lk_acc, lk_asid, er, ep, ew);
            n_tests++;
            if (lk_result !== er || lk_pa !== ep || lk_writable !== ew) begin
                n_fail++;
                $display("FAIL %s: va=%h acc=%0d result=%0d pa=%h wr=%b expected result=%0d pa=%h wr=%b",
                         cur_tag, lk_va, lk_acc, lk_result, lk_pa, lk_writable, er, ep, ew);
            end
        end
    end

    task automatic put(input int idx, input logic [31:0] vpn, input logic [31:0] pm,
                       input logic [7:0] asid, input bit g, input bit hide,
                       input logic [31:0] p0, input logic [31:0] p1,
                       input logic [3:0] f0, input logic [3:0] f1);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_idx = 4'(idx); wr_vpn = vpn; wr_pmask = pm; wr_asid = asid;
        wr_glob = g; wr_hide = hide; wr_pfn0 = p0; wr_pfn1 = p1;
        wr_flags0 = f0; wr_flags1 = f1;
        @(posedge clk); #1;
        wr_en = 1'b0;
        m_vpn[idx] = vpn; m_mask[idx] = pm; m_asid[idx] = asid; m_glob[idx] = g;
        m_hide[idx] = hide; m_pfn0[idx] = p0; m_pfn1[idx] = p1;
        m_f0[idx] = f0; m_f1[idx] = f1;
    endtask

    task automatic look(input logic [31:0] va, input logic [1:0] acc,
                        input logic [7:0] asid, input string tag);
        @(posedge clk); #1;
        lk_va = va; lk_acc = acc; lk_asid = asid; cur_tag = tag;
        @(negedge clk); #1;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_vpn[i] = '0; m_mask[i] = '0; m_pfn0[i] = '0; m_pfn1[i] = '0;
            m_asid[i] = '0; m_glob[i] = 0; m_hide[i] = 1; m_f0[i] = '0; m_f1[i] = '0;
        end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_on = 1'b1;
        // R10: reset leaves all entries hidden
        look(32'h0000_0000, 2'd1, 8'd0, "R10");
        look(32'h8040_1234, 2'd2, 8'd7, "R10");

        // R1 R3 R5 R6: 4 KiB pair, even half dirty, odd half clean
        put(3, 32'h0040_0000, 32'h0, 8'd5, 0, 0, 32'h1000_0000, 32'h2000_0000, 4'b0011, 4'b0001);
        look(32'h0040_0123, 2'd1, 8'd5, "R1");
        look(32'h0040_0123, 2'd2, 8'd5, "R6");
        look(32'h0040_1ABC, 2'd1, 8'd5, "R3");
        look(32'h0040_1ABC, 2'd2, 8'd5, "R5");
        look(32'h0040_0123, 2'd1, 8'd6, "R1");
        look(32'h0040_2000, 2'd1, 8'd5, "R7");
        // R1: global entry matches any identifier; hidden entry never hits
        put(4, 32'h0080_0000, 32'h0, 8'd9, 1, 0, 32'h3000_0000, 32'h3000_2000, 4'b0011, 4'b0011);
        look(32'h0080_0FFF, 2'd0, 8'd200, "R1");
        put(5, 32'h00C0_0000, 32'h0, 8'd1, 1, 1, 32'h3100_0000, 32'h3100_2000, 4'b0011, 4'b0011);
        look(32'h00C0_0010, 2'd1, 8'd1, "R1");
        // R2 R3: 16 KiB pages, odd half at bit 14, low mask bits ignored
        put(6, 32'h0100_0000, 32'h0000_6000, 8'd2, 0, 0, 32'h4000_0000, 32'h4004_0000, 4'b0011, 4'b0011);
        look(32'h0100_3FF0, 2'd1, 8'd2, "R2");
        look(32'h0100_4010, 2'd2, 8'd2, "R3");
        put(7, 32'h0200_0000, 32'h0000_0FFF, 8'd2, 0, 0, 32'h5000_0000, 32'h5000_2000, 4'b0011, 4'b0011);
        look(32'h0200_1ABC, 2'd1, 8'd2, "R2");
        // R4: check order
        put(8, 32'h0300_0000, 32'h0, 8'd3, 0, 0, 32'h6000_0000, 32'h6000_2000, 4'b1000, 4'b1101);
        look(32'h0300_0000, 2'd0, 8'd3, "R4");
        look(32'h0300_1000, 2'd0, 8'd3, "R4");
        look(32'h0300_1000, 2'd1, 8'd3, "R4");
        look(32'h0300_1000, 2'd2, 8'd3, "R4");
        put(9, 32'h0400_0000, 32'h0, 8'd3, 0, 0, 32'h6100_0000, 32'h6100_2000, 4'b0111, 4'b1011);
        look(32'h0400_0004, 2'd0, 8'd3, "R4");
        look(32'h0400_0004, 2'd2, 8'd3, "R4");
        look(32'h0400_1004, 2'd1, 8'd3, "R4");
        // R8: two entries hit, lowest index decides
        put(11, 32'h0500_0000, 32'h0, 8'd4, 0, 0, 32'h7100_0000, 32'h7100_2000, 4'b0011, 4'b0011);
        put(2,  32'h0500_0000, 32'h0, 8'd4, 0, 0, 32'h7200_0000, 32'h7200_2000, 4'b0000, 4'b0011);
        look(32'h0500_0040, 2'd1, 8'd4, "R8");
        look(32'h0500_1040, 2'd1, 8'd4, "R8");
        // R9: write and lookup in the same cycle
        @(posedge clk); #1;
        lk_va = 32'h0600_0020; lk_acc = 2'd1; lk_asid = 8'd8; cur_tag = "R9";
        wr_en = 1'b1; wr_idx = 4'd12; wr_vpn = 32'h0600_0000; wr_pmask = '0;
        wr_asid = 8'd8; wr_glob = 0; wr_hide = 0; wr_pfn0 = 32'h7700_0000;
        wr_pfn1 = 32'h7700_2000; wr_flags0 = 4'b0011; wr_flags1 = 4'b0011;
        @(posedge clk); #1;
        wr_en = 1'b0;
        m_vpn[12] = 32'h0600_0000; m_mask[12] = '0; m_asid[12] = 8'd8; m_glob[12] = 0;
        m_hide[12] = 0; m_pfn0[12] = 32'h7700_0000; m_pfn1[12] = 32'h7700_2000;
        m_f0[12] = 4'b0011; m_f1[12] = 4'b0011;
        @(negedge clk); #1;

        // R1 R4 R8: random sweep
        for (int k = 0; k < 400; k++) begin
            if (k % 3 == 0) begin
                int          sz = $urandom_range(0, 6);
                logic [31:0] pm = ((32'd1 << sz) - 1) << 13;
                logic [31:0] off = (pm | 32'h1FFF) >> 1;
                logic [31:0] vp = {5'($urandom_range(0, 3)), 27'($urandom)};
                put($urandom_range(0, 15), vp, pm, 8'($urandom_range(0, 3)),
                    ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                    $urandom & ~off, $urandom & ~off,
                    4'($urandom), 4'($urandom));
            end
            begin
                int idx = $urandom_range(0, 15);
                look(m_vpn[idx] ^ ($urandom & 32'h0003_FFFF), 2'($urandom_range(0, 2)),
                     8'($urandom_range(0, 3)), "R4");
            end
        end

        chk_on = 1'b0;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule